// File: doc/BRIEF.md
# Cartridge Bus Peek/Poke Engine

This block turns a stream of command bytes into bus cycles on an 8-bit cartridge port with sixteen address lines, a data bus and a read/write strobe. It sits behind a byte-stream serial link. It understands three operations: store one byte at an address, fetch one byte from an address, and fetch a run of consecutive addresses. A run returns its bytes back to back, so the host avoids framing overhead on every byte of a large image.

The engine has no knowledge of banking schemes. When a cartridge needs a bank selected, the host issues the ordinary stores or fetches that the cartridge decodes. The hardware stays the same for every cartridge type. Every bus access first holds the address for a programmable number of clocks. A store also keeps its data on the bus for that many clocks after the strobe is released, which suits slow parts and level shifters.

Top module: `cart_bus_engine`

## Requirements
- R1: After reset, bus_rw is high, bus_oe is low, tx_valid is low and rx_ready is high.
- R2: A store frame is the byte 0x01, then the address high byte, then the address low byte, then the data byte. It drives the data on bus_dout with bus_oe high and bus_rw low for exactly setup_cycles+1 clocks at that address. bus_rw is low at no other time.
- R3: Before bus_rw falls for a store, the address is presented with bus_rw high and bus_oe low for exactly setup_cycles+1 clocks.
- R4: After bus_rw returns high, a store keeps bus_oe high with unchanged data and address for exactly setup_cycles+1 clocks, then releases bus_oe.
- R5: A fetch frame is the byte 0x02, then the address high byte, then the address low byte. The address is held with bus_rw high for setup_cycles+1 clocks. The byte on bus_din is then returned as one tx_data byte.
- R6: A run frame is the byte 0x03, then the address high and low bytes, then the length high and low bytes. It returns exactly that many bytes, read from consecutive ascending addresses in order.
- R7: A run that passes address 0xFFFF continues at 0x0000.
- R8: A run of length zero returns no bytes, and the engine is ready for the next frame.
- R9: While tx_valid is high and tx_ready is low, tx_data, bus_addr and the bus strobes stay unchanged, and no further bus access starts.
- R10: An opcode byte other than 0x01, 0x02 or 0x03 causes no bus activity and no reply. The following byte is parsed as a new opcode.
- R11: rx_ready is low from the last byte of a frame until its bus work and reply are complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| setup_cycles | input | SETUP_W | Extra clocks of address setup and data hold per phase |
| rx_data | input | 8 | Incoming command byte |
| rx_valid | input | 1 | Incoming byte present |
| rx_ready | output | 1 | Engine accepts an incoming byte |
| tx_data | output | 8 | Reply byte |
| tx_valid | output | 1 | Reply byte present |
| tx_ready | input | 1 | Receiver takes the reply byte |
| bus_addr | output | 16 | Cartridge address lines |
| bus_rw | output | 1 | High for read, low for write |
| bus_dout | output | 8 | Data driven toward the cartridge |
| bus_oe | output | 1 | Enables bus_dout onto the data lines |
| bus_din | input | 8 | Data read from the cartridge |

## Verification
The assertions assume that setup_cycles does not change while a frame is being executed. They also assume that bus_din settles within one clock of an address change. The same checks hold whether tx_ready holds off a reply for many cycles or takes it at once. The bench changes setup_cycles only while the engine is idle between frames. It models the cartridge as a fixed function of bus_addr. It drops tx_ready both in long stretches and on alternate cycles, so the back-pressure checks meet both patterns.

// File: rtl/cart_bus_engine.sv
module cart_bus_engine #(
  parameter int SETUP_W = 4,
  parameter int AW      = 16,
  parameter int DW      = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SETUP_W-1:0] setup_cycles,
  input  logic [7:0]         rx_data,
  input  logic               rx_valid,
  output logic               rx_ready,
  output logic [DW-1:0]      tx_data,
  output logic               tx_valid,
  input  logic               tx_ready,
  output logic [AW-1:0]      bus_addr,
  output logic               bus_rw,
  output logic [DW-1:0]      bus_dout,
  output logic               bus_oe,
  input  logic [DW-1:0]      bus_din
);

  localparam logic [7:0] OP_POKE = 8'h01;
  localparam logic [7:0] OP_PEEK = 8'h02;
  localparam logic [7:0] OP_RUN  = 8'h03;

  typedef enum logic [3:0] {
    ST_OP, ST_AH, ST_AL, ST_DAT, ST_LH, ST_LL,
    ST_WSET, ST_WLOW, ST_WHOLD, ST_RSET, ST_RESP
  } state_t;

  state_t             st;
  logic [1:0]         op;
  logic [AW-1:0]      addr;
  logic [DW-1:0]      wdat, rdat;
  logic [15:0]        remain;
  logic [SETUP_W-1:0] cnt;
  logic               take;
  logic               cnt_done;

  assign rx_ready = (st == ST_OP) || (st == ST_AH) || (st == ST_AL) ||
                    (st == ST_DAT) || (st == ST_LH) || (st == ST_LL);
  assign take     = rx_valid && rx_ready;
  assign cnt_done = (cnt == '0);

  assign bus_addr = addr;
  assign bus_dout = wdat;
  assign bus_rw   = (st != ST_WLOW);
  assign bus_oe   = (st == ST_WLOW) || (st == ST_WHOLD);
  assign tx_valid = (st == ST_RESP);
  assign tx_data  = rdat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_OP;
      op     <= '0;
      addr   <= '0;
      wdat   <= '0;
      rdat   <= '0;
      remain <= '0;
      cnt    <= '0;
    end else begin
      unique case (st)
        ST_OP: if (take && (rx_data == OP_POKE || rx_data == OP_PEEK || rx_data == OP_RUN)) begin
          op <= rx_data[1:0];
          st <= ST_AH;
        end
        ST_AH: if (take) begin
          addr[AW-1:8] <= rx_data[AW-9:0];
          st           <= ST_AL;
        end
        ST_AL: if (take) begin
          addr[7:0] <= rx_data;
          cnt       <= setup_cycles;
          if (op == OP_POKE[1:0])      st <= ST_DAT;
          else if (op == OP_RUN[1:0])  st <= ST_LH;
          else begin
            remain <= 16'd1;
            st     <= ST_RSET;
          end
        end
        ST_DAT: if (take) begin
          wdat <= rx_data[DW-1:0];
          cnt  <= setup_cycles;
          st   <= ST_WSET;
        end
        ST_LH: if (take) begin
          remain[15:8] <= rx_data;
          st           <= ST_LL;
        end
        ST_LL: if (take) begin
          remain[7:0] <= rx_data;
          cnt         <= setup_cycles;
          st          <= ({remain[15:8], rx_data} == 16'd0) ? ST_OP : ST_RSET;
        end
        ST_WSET: if (cnt_done) begin
          cnt <= setup_cycles;
          st  <= ST_WLOW;
        end else cnt <= cnt - 1'b1;
        ST_WLOW: if (cnt_done) begin
          cnt <= setup_cycles;
          st  <= ST_WHOLD;
        end else cnt <= cnt - 1'b1;
        ST_WHOLD: if (cnt_done) st <= ST_OP;
                  else cnt <= cnt - 1'b1;
        ST_RSET: if (cnt_done) begin
          rdat <= bus_din;
          st   <= ST_RESP;
        end else cnt <= cnt - 1'b1;
        ST_RESP: if (tx_ready) begin
          remain <= remain - 16'd1;
          if (remain == 16'd1) st <= ST_OP;
          else begin
            addr <= addr + 1'b1;
            cnt  <= setup_cycles;
            st   <= ST_RSET;
          end
        end
        default: st <= ST_OP;
      endcase
    end
  end

  // R2
  rw_low_drives_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rw |-> bus_oe);

  // R3
  addr_stable_at_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rw) |-> $stable(bus_addr));

  // R4
  drive_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe && $past(bus_oe) |-> $stable(bus_dout) && $stable(bus_addr));

  // R5
  reply_while_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> bus_rw && !bus_oe);

  // R9
  reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(bus_addr));

  // R11
  no_accept_while_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !rx_ready);

endmodule

// File: tb/tb_cart_bus_engine.sv
module tb_cart_bus_engine;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] setup_cycles = 0;
  logic [7:0] rx_data = 0;
  logic       rx_valid = 0;
  logic       rx_ready;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_ready = 0;
  logic [15:0] bus_addr;
  logic       bus_rw;
  logic [7:0] bus_dout;
  logic       bus_oe;
  logic [7:0] bus_din;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  assign bus_din = mem(bus_addr);

  cart_bus_engine dut (
    .clk(clk), .rst_n(rst_n), .setup_cycles(setup_cycles),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .bus_addr(bus_addr), .bus_rw(bus_rw), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .bus_din(bus_din)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1;
    rx_data  = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(bus_rw && !bus_oe && !tx_valid && rx_ready, "R1 reset outputs",
        {bus_rw, bus_oe, tx_valid, rx_ready}, 4'b1001);
  endtask

  task automatic t_write(input logic [15:0] a, input logic [7:0] d, input logic [3:0] s);
    int n1 = 0, n2 = 0, n3 = 0, g = 0, bad = 0, busy = 0;
    setup_cycles = s;
    send_byte(8'h01); send_byte(a[15:8]); send_byte(a[7:0]); send_byte(d);
    while (bus_rw && !bus_oe && g < 300) begin
      if (bus_addr != a) bad++;
      if (rx_ready) busy++;
      n1++; g++; @(negedge clk);
    end
    while (!bus_rw && g < 300) begin
      if (!bus_oe || bus_dout != d || bus_addr != a) bad++;
      if (rx_ready) busy++;
      n2++; g++; @(negedge clk);
    end
    while (bus_rw && bus_oe && g < 300) begin
      if (bus_dout != d || bus_addr != a) bad++;
      if (rx_ready) busy++;
      n3++; g++; @(negedge clk);
    end
    chk(n1 == s + 1, "R3 address setup clocks", n1, s + 1);
    chk(n2 == s + 1 && bad == 0, "R2 write strobe clocks", n2, s + 1);
    chk(n3 == s + 1, "R4 data hold clocks", n3, s + 1);
    chk(bad == 0, "R2 write data/address", bad, 0);
    chk(busy == 0 && rx_ready, "R11 rx_ready during write", busy, 0);
  endtask

  task automatic t_read(input logic [15:0] a, input logic [3:0] s);
    int n = 0, bad = 0;
    setup_cycles = s;
    tx_ready = 0;
    send_byte(8'h02); send_byte(a[15:8]); send_byte(a[7:0]);
    while (!tx_valid && n < 300) begin
      if (bus_addr != a || !bus_rw || bus_oe || rx_ready) bad++;
      n++; @(negedge clk);
    end
    chk(n == s + 1, "R5 read setup clocks", n, s + 1);
    chk(bad == 0, "R5 read bus state", bad, 0);
    chk(tx_data == mem(a), "R5 read data", tx_data, mem(a));
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
    chk(!tx_valid && rx_ready, "R11 idle after read", {tx_valid, rx_ready}, 2'b01);
  endtask

  task automatic t_dump(input logic [15:0] a, input logic [15:0] l, input logic [3:0] s,
                        input bit toggle, input string req);
    int got = 0, bad = 0;
    int lim = l * (s + 4) * 2 + 60;
    setup_cycles = s;
    send_byte(8'h03); send_byte(a[15:8]); send_byte(a[7:0]);
    send_byte(l[15:8]); send_byte(l[7:0]);
    for (int i = 0; i < lim; i++) begin
      tx_ready = toggle ? ~tx_ready : 1'b1;
      if (tx_valid && tx_ready) begin
        logic [15:0] ea;
        ea = a + got[15:0];
        if (tx_data != mem(ea) || bus_addr != ea) bad++;
        got++;
      end
      @(negedge clk);
    end
    tx_ready = 0;
    chk(got == l, {req, " byte count"}, got, l);
    chk(bad == 0, {req, " byte values"}, bad, 0);
    chk(rx_ready && !tx_valid, {req, " idle after run"}, {rx_ready, tx_valid}, 2'b10);
  endtask

  task automatic t_backpressure(input logic [15:0] a);
    int g = 0, bad = 0;
    logic [7:0] d0;
    logic [15:0] a0;
    setup_cycles = 1;
    tx_ready = 0;
    send_byte(8'h03); send_byte(a[15:8]); send_byte(a[7:0]);
    send_byte(8'h00); send_byte(8'h02);
    while (!tx_valid && g < 100) begin g++; @(negedge clk); end
    d0 = tx_data; a0 = bus_addr;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (!tx_valid || tx_data != d0 || bus_addr != a0 || !bus_rw || bus_oe || rx_ready) bad++;
    end
    chk(bad == 0, "R9 reply held under back-pressure", bad, 0);
    chk(d0 == mem(a), "R9 held byte value", d0, mem(a));
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
    g = 0;
    while (!tx_valid && g < 100) begin g++; @(negedge clk); end
    chk(tx_data == mem(a + 16'd1), "R9 second byte after release", tx_data, mem(a + 16'd1));
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
  endtask

  task automatic t_junk();
    int bad = 0;
    send_byte(8'h7F);
    send_byte(8'h00);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!bus_rw || bus_oe || tx_valid || !rx_ready) bad++;
    end
    chk(bad == 0, "R10 unknown opcode ignored", bad, 0);
    t_read(16'h4321, 4'd0);
    chk(bus_addr == 16'h4321, "R10 resync address", bus_addr, 16'h4321);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_reset();
    t_write(16'h1234, 8'h5C, 4'd0);
    t_write(16'hF00D, 8'hA3, 4'd3);
    t_read(16'h0000, 4'd0);
    t_read(16'hBEEF, 4'd5);
    t_dump(16'h1000, 16'd16, 4'd0, 1'b0, "R6 run");
    t_dump(16'h2200, 16'd5, 4'd2, 1'b1, "R6 run toggled ready");
    t_dump(16'hFFFE, 16'd4, 4'd1, 1'b0, "R7 wrap");
    t_dump(16'h3000, 16'd0, 4'd0, 1'b0, "R8 zero length");
    t_backpressure(16'h5555);
    t_junk();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule